// File: doc/BRIEF.md
# Serial Command Decoder and Register File for a 16-Channel Low-Side Driver

This block is the serial slave that sits in front of a sixteen-channel low-side switch controller. A host selects it by pulling chip select low and clocks a 24-bit word in on the serial input, most significant bit first. Bits 23 to 18 of that word hold an operation code, and bits 15 to 0 hold one bit per output channel. While the host clocks its word in, the block clocks a 24-bit status word out on the serial output. That status word is a snapshot of the fault inputs, taken when chip select falls.

The command takes effect only when chip select rises, and only if the number of serial clock falling edges seen during the frame is a non-zero multiple of 24. It updates one of six control registers: output on/off, open-load current enable, short-fault protect mode, PWM enable, AND/OR combine select, and a two-bit global retry policy. One operation code acts as a soft reset. Because the input and output share a single shift path, several devices can be chained: the word that enters one device reappears at its output 24 clocks later. All pins are sampled with the system clock through synchronizer stages. Fault detection and gate drive live elsewhere; this block only exports register contents and takes in fault status.

Top module: `lsd_spi_top`

## Requirements
- R1: After the synchronous reset, or while the active-low reset pin is held low, every register reads 0 except the short-fault protect register, which reads all ones. The serial output enable is low while chip select is high.
- R2: Opcode 000000 (bits 23..18) loads bits 15..0 into the on/off register.
- R3: Opcodes 000001, 000011, 000100 and 000101 load bits 15..0 into, respectively, the open-load enable, short-fault protect, PWM enable and AND/OR select registers, and leave every other register unchanged.
- R4: Opcode 000010 loads bit 17 into the thermal-retry flag and bit 16 into the over-voltage-resume flag, and ignores bits 15..0.
- R5: Opcode 000110 returns the on/off, PWM enable and AND/OR registers to 0 and the short-fault protect register to all ones. It leaves the open-load enable and retry registers as they were.
- R6: No register changes while chip select is low; a frame's effect appears only after chip select rises.
- R7: A frame whose count of serial clock falling edges is zero or not a multiple of 24 changes no register.
- R8: Opcodes 000111 through 111111 change no register.
- R9: The word sent out on the serial output, MSB first, is {any-fault, over-voltage, six zeros, fault[15:0]}. Any-fault is the OR of the over-voltage flag and all output faults. Bit 23 is on the output once chip select falls, and each later bit appears after a rising serial clock edge.
- R10: In a 48-clock frame, serial output bits 24..47 repeat the first 24 input bits in order, and only the last 24 input bits are executed.
- R11: While chip select is high, toggling the serial clock and data changes no register, and the serial output enable stays low.
- R12: Fault inputs that change after chip select falls do not alter the status word being shifted out in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst | input | 1 | Synchronous active-high power-on reset |
| rst_pin_n | input | 1 | Active-low external reset pin (asynchronous, synchronized inside) |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| ov_fault | input | 1 | Over-voltage status flag |
| out_fault | input | 16 | Per-output fault flags |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for the serial data out driver |
| on_off | output | 16 | On/off register |
| ol_en | output | 16 | Open-load current enable register |
| sfpd | output | 16 | Short-fault protect mode register |
| pwm_en | output | 16 | PWM enable register |
| and_or | output | 16 | AND/OR combine select register |
| retry_thermal | output | 1 | Thermal retry flag |
| retry_ov | output | 1 | Over-voltage resume flag |

## Verification
A wrong bit counter shows up at the ports as a register that changes after a truncated or overlong frame, or that stays put after a valid one. Either is visible within a few system clocks of chip select rising. A fault in the shift path shows up bit by bit on the serial output: a wrong snapshot corrupts the first 24 bits, and a broken chain path corrupts bits 24 to 47 of a double-length frame. Decode errors, such as a soft reset that clears the wrong registers or an unknown opcode that writes, show up on the register outputs right after chip select rises.

// File: rtl/lsd_spi_pkg.sv
package lsd_spi_pkg;

    localparam int unsigned FRAME_W = 24;
    localparam int unsigned DATA_W  = 16;
    localparam int unsigned OP_W    = 6;
    localparam int unsigned OP_LSB  = FRAME_W - OP_W;
    localparam int unsigned CNT_W   = $clog2(FRAME_W);

    typedef enum logic [OP_W-1:0] {
        OP_ONOFF   = 6'd0,
        OP_OLEN    = 6'd1,
        OP_RETRY   = 6'd2,
        OP_SFPD    = 6'd3,
        OP_PWMEN   = 6'd4,
        OP_ANDOR   = 6'd5,
        OP_SOFTRST = 6'd6
    } opcode_e;

    typedef struct packed {
        logic [DATA_W-1:0] on_off;
        logic [DATA_W-1:0] ol_en;
        logic [DATA_W-1:0] sfpd;
        logic [DATA_W-1:0] pwm_en;
        logic [DATA_W-1:0] and_or;
        logic              rt_thermal;
        logic              rt_ov;
    } ctrl_regs_t;

    function automatic ctrl_regs_t por_regs();
        ctrl_regs_t r;
        r.on_off     = '0;
        r.ol_en      = '0;
        r.sfpd       = '1;
        r.pwm_en     = '0;
        r.and_or     = '0;
        r.rt_thermal = 1'b0;
        r.rt_ov      = 1'b0;
        return r;
    endfunction

    function automatic logic [FRAME_W-1:0] pack_status(
        input logic              ov,
        input logic [DATA_W-1:0] flt
    );
        return {ov | (|flt), ov, {(FRAME_W-DATA_W-2){1'b0}}, flt};
    endfunction

endpackage

// File: rtl/lsd_spi_sync.sv
module lsd_spi_sync #(
    parameter int unsigned      W        = 4,
    parameter int unsigned      STAGES   = 2,
    parameter logic [W-1:0]     INIT_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[k] <= INIT_VAL;
                else     stg[k] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[k] <= INIT_VAL;
                else     stg[k] <= stg[k-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/lsd_spi_shifter.sv
module lsd_spi_shifter
    import lsd_spi_pkg::*;
(
    input  logic               clk,
    input  logic               clr,
    input  logic               sclk_s,
    input  logic               cs_n_s,
    input  logic               si_s,
    input  logic [FRAME_W-1:0] status_word,
    output logic               so_bit,
    output logic [FRAME_W-1:0] frame_word,
    output logic               frame_go
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] sr;
    logic [CNT_W-1:0]   cnt;
    logic               seen;
    logic               sclk_q, cs_q, so_q, go_q;
    logic               cs_fall, cs_rise, sclk_rise, sclk_fall;

    assign cs_fall   = !cs_n_s && cs_q;
    assign cs_rise   = cs_n_s && !cs_q;
    assign sclk_rise = sclk_s && !sclk_q;
    assign sclk_fall = !sclk_s && sclk_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            sr     <= '0;
            cnt    <= '0;
            seen   <= 1'b0;
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
            so_q   <= 1'b0;
            go_q   <= 1'b0;
        end else begin
            sclk_q <= sclk_s;
            cs_q   <= cs_n_s;
            go_q   <= cs_rise && seen && (cnt == '0);
            if (cs_fall) begin
                sr   <= status_word;
                so_q <= status_word[FRAME_W-1];
                cnt  <= '0;
                seen <= 1'b0;
            end else if (!cs_n_s) begin
                if (sclk_rise) so_q <= sr[FRAME_W-1];
                if (sclk_fall) begin
                    sr   <= {sr[FRAME_W-2:0], si_s};
                    cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
                    seen <= 1'b1;
                end
            end
        end
    end

    assign so_bit     = so_q;
    assign frame_word = sr;
    assign frame_go   = go_q;

    p_cnt_range_r7: assert property (@(posedge clk) disable iff (clr)
        cnt <= LAST);
    p_go_boundary_r7: assert property (@(posedge clk) disable iff (clr)
        frame_go |-> (seen && cnt == '0 && cs_n_s));
    p_idle_silent_r11: assert property (@(posedge clk) disable iff (clr)
        (cs_n_s && cs_q) |=> $stable(sr));
endmodule

// File: rtl/lsd_spi_regfile.sv
module lsd_spi_regfile
    import lsd_spi_pkg::*;
(
    input  logic               clk,
    input  logic               clr,
    input  logic               go,
    input  logic [FRAME_W-1:0] word,
    output ctrl_regs_t         regs
);
    ctrl_regs_t        q;
    logic [OP_W-1:0]   op;
    logic [DATA_W-1:0] dat;
    ctrl_regs_t        por;

    assign op  = word[FRAME_W-1:OP_LSB];
    assign dat = word[DATA_W-1:0];
    assign por = por_regs();

    always_ff @(posedge clk) begin
        if (clr) begin
            q <= por;
        end else if (go) begin
            case (op)
                OP_ONOFF:  q.on_off <= dat;
                OP_OLEN:   q.ol_en  <= dat;
                OP_SFPD:   q.sfpd   <= dat;
                OP_PWMEN:  q.pwm_en <= dat;
                OP_ANDOR:  q.and_or <= dat;
                OP_RETRY: begin
                    q.rt_thermal <= word[DATA_W+1];
                    q.rt_ov      <= word[DATA_W];
                end
                OP_SOFTRST: begin
                    q.on_off <= por.on_off;
                    q.sfpd   <= por.sfpd;
                    q.pwm_en <= por.pwm_en;
                    q.and_or <= por.and_or;
                end
                default: ;
            endcase
        end
    end

    assign regs = q;

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (clr)
        !go |=> $stable(q));
    p_softrst_keeps_r5: assert property (@(posedge clk) disable iff (clr)
        (go && op == OP_SOFTRST) |=> ($stable(q.ol_en) && $stable(q.rt_thermal)
                                      && $stable(q.rt_ov) && (&q.sfpd) && q.on_off == '0));
    p_unknown_op_r8: assert property (@(posedge clk) disable iff (clr)
        (go && op > OP_SOFTRST) |=> $stable(q));
endmodule

// File: rtl/lsd_spi_top.sv
module lsd_spi_top
    import lsd_spi_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rst_pin_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              si,
    input  logic              ov_fault,
    input  logic [DATA_W-1:0] out_fault,
    output logic              so,
    output logic              so_oe,
    output logic [DATA_W-1:0] on_off,
    output logic [DATA_W-1:0] ol_en,
    output logic [DATA_W-1:0] sfpd,
    output logic [DATA_W-1:0] pwm_en,
    output logic [DATA_W-1:0] and_or,
    output logic              retry_thermal,
    output logic              retry_ov
);
    localparam int unsigned NPIN = 4;

    logic [NPIN-1:0]    pins_s;
    logic               sclk_s, cs_n_s, si_s, rstpin_s, clr;
    logic [FRAME_W-1:0] word;
    logic               go;
    ctrl_regs_t         regs;

    lsd_spi_sync #(
        .W        (NPIN),
        .STAGES   (SYNC_STAGES),
        .INIT_VAL (4'b0010)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({rst_pin_n, si, cs_n, sclk}),
        .q   (pins_s)
    );

    assign sclk_s   = pins_s[0];
    assign cs_n_s   = pins_s[1];
    assign si_s     = pins_s[2];
    assign rstpin_s = pins_s[3];
    assign clr      = rst || !rstpin_s;

    lsd_spi_shifter u_shift (
        .clk         (clk),
        .clr         (clr),
        .sclk_s      (sclk_s),
        .cs_n_s      (cs_n_s),
        .si_s        (si_s),
        .status_word (pack_status(ov_fault, out_fault)),
        .so_bit      (so),
        .frame_word  (word),
        .frame_go    (go)
    );

    lsd_spi_regfile u_regs (
        .clk  (clk),
        .clr  (clr),
        .go   (go),
        .word (word),
        .regs (regs)
    );

    assign so_oe         = !cs_n_s;
    assign on_off        = regs.on_off;
    assign ol_en         = regs.ol_en;
    assign sfpd          = regs.sfpd;
    assign pwm_en        = regs.pwm_en;
    assign and_or        = regs.and_or;
    assign retry_thermal = regs.rt_thermal;
    assign retry_ov      = regs.rt_ov;

    p_first_bit_r9: assert property (@(posedge clk) disable iff (clr)
        $fell(cs_n_s) |=> so == ($past(ov_fault) || (|$past(out_fault))));
endmodule

// File: tb/lsd_spi_top_tb_top.sv
module lsd_spi_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rst_pin_n = 1'b1;
    logic        sclk = 1'b0, cs_n = 1'b1, si = 1'b0;
    logic        ov_fault = 1'b0;
    logic [15:0] out_fault = '0;
    logic        so, so_oe, retry_thermal, retry_ov;
    logic [15:0] on_off, ol_en, sfpd, pwm_en, and_or;

    int n_checks = 0;
    int n_fail   = 0;

    logic [15:0] m_on, m_ol, m_sf, m_pw, m_ao;
    logic [1:0]  m_rt;

    typedef struct {
        logic  val;
        string tag;
    } so_item_t;
    so_item_t exp_q[$];

    always #5 clk = ~clk;

    lsd_spi_top dut_i (
        .clk(clk), .rst(rst), .rst_pin_n(rst_pin_n), .sclk(sclk), .cs_n(cs_n), .si(si),
        .ov_fault(ov_fault), .out_fault(out_fault), .so(so), .so_oe(so_oe),
        .on_off(on_off), .ol_en(ol_en), .sfpd(sfpd), .pwm_en(pwm_en), .and_or(and_or),
        .retry_thermal(retry_thermal), .retry_ov(retry_ov)
    );

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_por();
        m_on = '0; m_ol = '0; m_sf = '1; m_pw = '0; m_ao = '0; m_rt = 2'b00;
    endtask

    task automatic model_exec(input logic [23:0] w);
        case (w[23:18])
            6'd0: m_on = w[15:0];
            6'd1: m_ol = w[15:0];
            6'd2: m_rt = w[17:16];
            6'd3: m_sf = w[15:0];
            6'd4: m_pw = w[15:0];
            6'd5: m_ao = w[15:0];
            6'd6: begin m_on = '0; m_sf = '1; m_pw = '0; m_ao = '0; end
            default: ;
        endcase
    endtask

    task automatic check_regs(input string tag);
        chk(on_off, m_on, {tag, " on_off"});
        chk(ol_en,  m_ol, {tag, " ol_en"});
        chk(sfpd,   m_sf, {tag, " sfpd"});
        chk(pwm_en, m_pw, {tag, " pwm_en"});
        chk(and_or, m_ao, {tag, " and_or"});
        chk({14'd0, retry_thermal, retry_ov}, {14'd0, m_rt}, {tag, " retry"});
    endtask

    // Driver: pushes expected SO bits, clocks the frame, applies the model on CS rise.
    task automatic spi_frame(input logic [47:0] w, input int nbits, input string reg_tag,
                             input string so_tag, input logic chg,
                             input logic new_ov, input logic [15:0] new_f);
        logic [23:0] st;
        st = {ov_fault | (|out_fault), ov_fault, 6'd0, out_fault};
        for (int i = 0; i < nbits; i++) begin
            so_item_t it;
            it.val = (i < 24) ? st[23-i] : w[nbits-1-(i-24)];
            it.tag = (i < 24) ? so_tag : "R10";
            exp_q.push_back(it);
        end
        cs_n = 1'b0;
        wait_n(6);
        for (int i = 0; i < nbits; i++) begin
            si = w[nbits-1-i];
            if (chg && i == 8) begin ov_fault = new_ov; out_fault = new_f; end
            wait_n(2);
            sclk = 1'b1;
            wait_n(6);
            sclk = 1'b0;
            wait_n(6);
        end
        wait_n(4);
        check_regs("R6 before cs rise");
        cs_n = 1'b1;
        wait_n(8);
        if (nbits > 0 && nbits % 24 == 0) model_exec(w[23:0]);
        check_regs(reg_tag);
        chk({15'd0, so_oe}, 16'd0, "R1 so_oe low when idle");
    endtask

    // Monitor: pops one expected SO bit per rising SCLK inside a frame.
    initial begin
        forever begin
            @(posedge sclk);
            if (!cs_n) begin
                wait_n(5);
                n_checks++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R9: unexpected SO bit actual %b expected none", so);
                end else begin
                    so_item_t it;
                    it = exp_q.pop_front();
                    if (so !== it.val) begin
                        n_fail++;
                        $display("FAIL %s: SO actual %b expected %b", it.tag, so, it.val);
                    end
                end
            end
        end
    end

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        model_por();
        wait_n(5);
        rst = 1'b0;
        wait_n(5);
        check_regs("R1 reset");
        chk({15'd0, so_oe}, 16'd0, "R1 so_oe");

        out_fault = 16'h0010;
        spi_frame({24'd0, 6'd0, 2'b00, 16'hA5C3}, 24, "R2", "R9", 1'b0, 1'b0, '0);
        spi_frame({24'd0, 6'd1, 2'b00, 16'h0F0F}, 24, "R3 olen", "R9", 1'b0, 1'b0, '0);
        spi_frame({24'd0, 6'd3, 2'b00, 16'h1234}, 24, "R3 sfpd", "R9", 1'b0, 1'b0, '0);
        spi_frame({24'd0, 6'd4, 2'b00, 16'h00FF}, 24, "R3 pwm", "R9", 1'b0, 1'b0, '0);
        spi_frame({24'd0, 6'd5, 2'b00, 16'hF000}, 24, "R3 andor", "R9", 1'b0, 1'b0, '0);
        spi_frame({24'd0, 6'd2, 2'b10, 16'hFFFF}, 24, "R4 thermal", "R9", 1'b0, 1'b0, '0);
        spi_frame({24'd0, 6'd2, 2'b01, 16'h0000}, 24, "R4 ov", "R9", 1'b0, 1'b0, '0);
        spi_frame({24'd0, 6'd6, 2'b11, 16'hFFFF}, 24, "R5 softrst", "R9", 1'b0, 1'b0, '0);
        spi_frame({24'd0, 6'd0, 2'b00, 16'h00C3}, 24, "R2 again", "R9", 1'b0, 1'b0, '0);

        spi_frame({25'd0, 6'd0, 2'b00, 15'h1111}, 23, "R7 short", "R9", 1'b0, 1'b0, '0);
        spi_frame({23'd0, 1'b1, 6'd0, 2'b00, 16'h2222}, 25, "R7 long", "R9", 1'b0, 1'b0, '0);
        spi_frame({24'd0, 6'd7, 2'b11, 16'hFFFF}, 24, "R8 op7", "R9", 1'b0, 1'b0, '0);
        spi_frame({24'd0, 6'd63, 2'b11, 16'h5555}, 24, "R8 op63", "R9", 1'b0, 1'b0, '0);

        spi_frame({6'd0, 2'b00, 16'h3C3C, 6'd4, 2'b00, 16'h0A0A}, 48, "R10 chain", "R9",
                  1'b0, 1'b0, '0);

        out_fault = '0;
        ov_fault  = 1'b1;
        spi_frame({24'd0, 6'd5, 2'b00, 16'h0001}, 24, "R3 andor2", "R9", 1'b0, 1'b0, '0);
        ov_fault  = 1'b0;
        spi_frame({24'd0, 6'd0, 2'b00, 16'h00AA}, 24, "R2 snap", "R12", 1'b1, 1'b1, 16'hFFFF);
        spi_frame({24'd0, 6'd1, 2'b00, 16'h8001}, 24, "R3 olen2", "R9", 1'b0, 1'b0, '0);

        // R11: bus activity with chip select high
        for (int i = 0; i < 30; i++) begin
            si = i[0];
            sclk = 1'b1; wait_n(4);
            sclk = 1'b0; wait_n(4);
            if (i == 15) chk({15'd0, so_oe}, 16'd0, "R11 so_oe during idle clocking");
        end
        si = 1'b0;
        wait_n(6);
        check_regs("R11 idle clocking");

        // R1: reset pin
        rst_pin_n = 1'b0;
        wait_n(6);
        model_por();
        check_regs("R1 reset pin held");
        rst_pin_n = 1'b1;
        wait_n(6);
        check_regs("R1 reset pin released");

        wait_n(10);
        chk(16'(exp_q.size()), 16'd0, "R9 all SO bits observed");
        report();
    end
endmodule